// File: doc/BRIEF.md
# Block-framed UART transmitter

This block turns bytes into asynchronous serial frames for a link that moves data in fixed-length blocks. A writer loads bytes into a four-entry buffer one group at a time. A group is the whole block when the block has fewer than four bytes. Otherwise a group is four bytes, and the last group holds whatever is left of the block. When a group is complete, the buffer hands its bytes to a shift stage one after another. A free-running tick generator, restarted at the start of each frame, sets the bit time from a two-way prescaler and an 8-bit divider.

Each block can carry a parity bit on every byte, or two CRC-CCITT check bytes after its last byte. A wakeup mode adds a ninth bit that marks the first byte of each block. A block starts only when the link partner is clear to receive and transmit is enabled. Once a block has started it runs to the end. The host sees three flags: buffer empty, transmitter idle, and a one-cycle pulse when a whole block has left the line.

Top module: `blk_uart_tx`

## Requirements
- R1: After reset `txd_o` is 1, `fifo_empty_o` is 1, `tx_idle_o` is 1 and `pkt_done_o` is 0.
- R2: One bit on the line lasts P*(n+1)*16 clock cycles. P is 2 when `cfg_presc_sel_i`=0 and 32 when it is 1, and n is `cfg_div_i`. The start bit lasts exactly one full bit time.
- R3: A frame is sent in this order: a start bit of 0, then the 8 data bits with the LSB first, then the wakeup bit if enabled, then the parity bit if enabled, then stop bits of 1. The line carries `cfg_two_stop_i`+2 stop bits. When idle, the line is 1.
- R4: A block's first byte leaves only while `tx_en_i`=1 and `cts_ni`=0. After that byte has gone out, the rest of the block is sent whatever these two inputs do.
- R5: The buffer takes writes only while it is filling a group. The group size is min(bytes left in the block, 4), and the block is `cfg_blk_len_i`+1 bytes. A write made while the buffer is draining is dropped and never reaches the line.
- R6: When CRC is on and parity is off, two check bytes follow the block's last data byte, high byte first. The check is CRC-CCITT (polynomial 0x1021, fed MSB first). It starts from 0xFFFF at each block and covers the data bytes only.
- R7: When parity is on, parity bits are sent and no check bytes are sent, whether or not CRC is also on. With `cfg_par_even_i`=1 the parity bit is the XOR of the 8 data bits. With `cfg_par_even_i`=0 it is the inverse of that XOR.
- R8: With `cfg_wake_en_i`=1, the wakeup bit is 1 on the first byte of a block. It is 0 on every other data byte and on both check bytes.
- R9: `pkt_done_o` is a one-cycle pulse, given once per block, in the cycle after the last stop bit of the block's final frame.
- R10: `fifo_empty_o` is 1 exactly when the buffer holds no bytes. `tx_idle_o` is 1 when the buffer is empty, the shift stage is empty and no check byte is waiting to go out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to write |
| cfg_presc_sel_i | input | 1 | Prescaler select: 0 divides by 2, 1 divides by 32 |
| cfg_div_i | input | 8 | Divider setting n, divides by n+1 |
| cfg_blk_len_i | input | 6 | Block length minus one |
| cfg_par_en_i | input | 1 | Parity enable |
| cfg_par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_crc_en_i | input | 1 | Check-byte enable |
| cfg_two_stop_i | input | 1 | 1 configures two stop bits, 0 configures one |
| cfg_wake_en_i | input | 1 | Wakeup bit enable |
| tx_en_i | input | 1 | Transmit enable |
| cts_ni | input | 1 | Clear to send, active low |
| txd_o | output | 1 | Serial line |
| fifo_empty_o | output | 1 | Buffer holds no bytes |
| tx_idle_o | output | 1 | Nothing is waiting or being sent |
| pkt_done_o | output | 1 | Block-complete pulse |

## Verification
Blocks of 1, 3, 6, 8 and 64 bytes cover three cases: a single group, an exact multiple of four, and a short remainder group. These lengths separate the group-size rule from a plain per-byte buffer. Random blocks vary the stop-bit count, parity sense, the wakeup and check-byte options, and the divider. Each decoded frame is compared with frames built from the requirements, so any error in bit order, field placement or CRC shows up. Directed blocks check the slow prescaler setting, parity and CRC enabled together, and holding off a block with the clear-to-send or enable input and then dropping clear-to-send in the middle of the block. A junk write during draining and a quiet-line window after each block show that dropped writes and extra frames are caught.

// File: rtl/blk_tx_pkg.sv
package blk_tx_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_W    = 14;
  localparam int NBITS_W    = 4;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    PH_DATA   = 2'd0,
    PH_CRC_HI = 2'd1,
    PH_CRC_LO = 2'd2
  } tx_phase_e;

  function automatic logic [15:0] crc_ccitt_byte(input logic [15:0] c, input logic [DATA_W-1:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/btx_baud_gen.sv
module btx_baud_gen #(
  parameter int DIV_W  = 8,
  parameter int OVS    = 16,
  parameter int PRE_LO = 2,
  parameter int PRE_HI = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             presc_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bit_tick_o
);
  localparam int PW = (PRE_HI > 1) ? $clog2(PRE_HI) : 1;
  localparam int OW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [PW-1:0] PRE_LO_LAST = PW'(PRE_LO - 1);
  localparam logic [PW-1:0] PRE_HI_LAST = PW'(PRE_HI - 1);
  localparam logic [OW-1:0] OVS_LAST    = OW'(OVS - 1);

  logic [PW-1:0]    pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [OW-1:0]    ovs_cnt;
  logic pre_wrap, div_wrap;

  assign pre_wrap   = pre_cnt == (presc_sel_i ? PRE_HI_LAST : PRE_LO_LAST);
  assign div_wrap   = pre_wrap && (div_cnt == div_i);
  assign bit_tick_o = div_wrap && (ovs_cnt == OVS_LAST) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      ovs_cnt <= '0;
    end else if (clr_i) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      ovs_cnt <= '0;
    end else begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) div_cnt <= (div_cnt == div_i) ? '0 : div_cnt + 1'b1;
      if (div_wrap) ovs_cnt <= (ovs_cnt == OVS_LAST) ? '0 : ovs_cnt + 1'b1;
    end
  end

  // a bit lasts at least PRE_LO*OVS cycles, so ticks never come back to back
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);
endmodule

// File: rtl/btx_group_fifo.sv
module btx_group_fifo #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 6,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic             pop_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             ready_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int REM_W = LEN_W + 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, grp_left;
  logic [REM_W-1:0] wr_rem;
  logic             drain;

  logic [REM_W-1:0] rem_eff;
  logic [CNT_W-1:0] grp_new, grp_cur;
  logic             accept, do_pop;

  // bytes of the current block not yet written; zero means a new block begins
  assign rem_eff = (wr_rem == '0) ? REM_W'(blk_len_i) + 1'b1 : wr_rem;
  assign grp_new = (rem_eff > REM_W'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(rem_eff);
  assign grp_cur = (count == '0) ? grp_new : grp_left;
  assign accept  = wr_valid_i && !drain;
  assign do_pop  = pop_i && drain && (count != '0);

  assign rd_data_o = mem[rd_ptr];
  assign ready_o   = drain && (count != '0);
  assign empty_o   = count == '0;

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      grp_left <= '0;
      wr_rem   <= '0;
      drain    <= 1'b0;
    end else begin
      if (accept) begin
        wr_ptr   <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
        count    <= count + 1'b1;
        wr_rem   <= rem_eff - 1'b1;
        grp_left <= grp_cur - 1'b1;
        if (grp_cur == CNT_W'(1)) drain <= 1'b1;
      end else if (do_pop) begin
        rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
        count  <= count - 1'b1;
        if (count == CNT_W'(1)) drain <= 1'b0;
      end
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));
  assert_drain_ignores_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain && !pop_i) |=> (count == $past(count)) && (wr_ptr == $past(wr_ptr)));
endmodule

// File: rtl/btx_framer.sv
module btx_framer #(
  parameter int FW = 14,
  parameter int NW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [FW-1:0] frame_i,
  input  logic [NW-1:0] nbits_i,
  input  logic          bit_tick_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          txd_o
);
  logic [FW-1:0] sh;
  logic [NW-1:0] left;

  assign txd_o = busy_o ? sh[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '1;
      left   <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i && !busy_o) begin
        sh     <= frame_i;
        left   <= nbits_i;
        busy_o <= 1'b1;
      end else if (busy_o && bit_tick_i) begin
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 1'b1;
        if (left == NW'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assert_line_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_tick_i) |=> $stable(txd_o));
endmodule

// File: rtl/blk_uart_tx.sv
module blk_uart_tx
  import blk_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 6,
  parameter int DIV_W      = 8,
  parameter int OVS        = 16,
  parameter int PRE_LO     = 2,
  parameter int PRE_HI     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  input  logic             cfg_presc_sel_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [LEN_W-1:0] cfg_blk_len_i,
  input  logic             cfg_par_en_i,
  input  logic             cfg_par_even_i,
  input  logic             cfg_crc_en_i,
  input  logic             cfg_two_stop_i,
  input  logic             cfg_wake_en_i,
  input  logic             tx_en_i,
  input  logic             cts_ni,
  output logic             txd_o,
  output logic             fifo_empty_o,
  output logic             tx_idle_o,
  output logic             pkt_done_o
);
  logic [DATA_W-1:0] fifo_data;
  logic              fifo_ready;
  logic              bit_tick, fr_busy, fr_done;

  tx_phase_e         phase;
  logic              in_block, last_frame;
  logic [LEN_W-1:0]  tx_rem;
  logic [15:0]       crc;

  logic              crc_on, gate_open, load_data, load_crc, load, last_data;
  logic [DATA_W-1:0] cur_byte;
  logic              wake_bit, par_bit;
  logic [FRAME_W-1:0] frame;
  logic [NBITS_W-1:0] nbits, pos;

  btx_baud_gen #(.DIV_W(DIV_W), .OVS(OVS), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_baud (
    .clk_i, .rst_ni,
    .clr_i      (!fr_busy),
    .presc_sel_i(cfg_presc_sel_i),
    .div_i      (cfg_div_i),
    .bit_tick_o (bit_tick)
  );

  btx_group_fifo #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W), .DW(DATA_W)) u_fifo (
    .clk_i, .rst_ni,
    .wr_valid_i, .wr_data_i,
    .blk_len_i(cfg_blk_len_i),
    .pop_i    (load_data),
    .rd_data_o(fifo_data),
    .ready_o  (fifo_ready),
    .empty_o  (fifo_empty_o)
  );

  btx_framer #(.FW(FRAME_W), .NW(NBITS_W)) u_framer (
    .clk_i, .rst_ni,
    .load_i    (load),
    .frame_i   (frame),
    .nbits_i   (nbits),
    .bit_tick_i(bit_tick),
    .busy_o    (fr_busy),
    .done_o    (fr_done),
    .txd_o
  );

  // parity has priority over the check bytes
  assign crc_on    = cfg_crc_en_i && !cfg_par_en_i;
  assign gate_open = in_block || (tx_en_i && !cts_ni);
  assign load_data = !fr_busy && !fr_done && (phase == PH_DATA) && fifo_ready && gate_open;
  assign load_crc  = !fr_busy && !fr_done && (phase != PH_DATA);
  assign load      = load_data || load_crc;
  assign last_data = in_block ? (tx_rem == LEN_W'(1)) : (cfg_blk_len_i == '0);

  always_comb begin
    unique case (phase)
      PH_CRC_HI: cur_byte = crc[15:8];
      PH_CRC_LO: cur_byte = crc[7:0];
      default:   cur_byte = fifo_data;
    endcase
    wake_bit = (phase == PH_DATA) && !in_block;
    par_bit  = cfg_par_even_i ? ^cur_byte : ~^cur_byte;
    frame    = '1;
    frame[0] = 1'b0;
    frame[DATA_W:1] = cur_byte;
    pos = NBITS_W'(DATA_W + 1);
    if (cfg_wake_en_i) begin
      frame[pos] = wake_bit;
      pos = pos + 1'b1;
    end
    if (cfg_par_en_i) begin
      frame[pos] = par_bit;
      pos = pos + 1'b1;
    end
    // the line always carries one stop bit beyond the configured count
    nbits = pos + (cfg_two_stop_i ? NBITS_W'(3) : NBITS_W'(2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase      <= PH_DATA;
      in_block   <= 1'b0;
      last_frame <= 1'b0;
      tx_rem     <= '0;
      crc        <= CRC_INIT;
    end else begin
      if (load_data) begin
        crc      <= crc_ccitt_byte(in_block ? crc : CRC_INIT, fifo_data);
        in_block <= 1'b1;
        tx_rem   <= in_block ? tx_rem - 1'b1 : cfg_blk_len_i;
        if (last_data && crc_on) begin
          phase      <= PH_CRC_HI;
          last_frame <= 1'b0;
        end else begin
          last_frame <= last_data;
        end
      end else if (load_crc) begin
        phase      <= (phase == PH_CRC_HI) ? PH_CRC_LO : PH_DATA;
        last_frame <= (phase == PH_CRC_LO);
      end else if (fr_done && last_frame) begin
        in_block   <= 1'b0;
        last_frame <= 1'b0;
      end
    end
  end

  assign pkt_done_o = fr_done && last_frame;
  assign tx_idle_o  = fifo_empty_o && !fr_busy && (phase == PH_DATA);

  assert_start_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fr_busy) && !$past(in_block)) |-> ($past(tx_en_i) && !$past(cts_ni)));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |=> !pkt_done_o);
  assert_idle_mark_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> txd_o);
  assert_crc_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_CRC_HI && load_crc) |=> (phase == PH_CRC_LO));
endmodule

// File: tb/sim_blk_uart_tx.sv
`timescale 1ns/1ps
module sim_blk_uart_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic presc_sel = 1'b0;
  logic [7:0] div = '0;
  logic [5:0] blk_len = '0;
  logic par_en = 1'b0, par_even = 1'b0, crc_en = 1'b0, two_stop = 1'b0, wake_en = 1'b0;
  logic tx_en = 1'b1, cts_n = 1'b0;
  logic txd, fifo_empty, tx_idle, pkt_done;

  int total = 0, bad = 0, pd_cnt = 0, bt = 32;
  bit finished = 0;

  always #2 clk = ~clk;

  blk_uart_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .cfg_presc_sel_i(presc_sel), .cfg_div_i(div), .cfg_blk_len_i(blk_len),
    .cfg_par_en_i(par_en), .cfg_par_even_i(par_even), .cfg_crc_en_i(crc_en),
    .cfg_two_stop_i(two_stop), .cfg_wake_en_i(wake_en), .tx_en_i(tx_en),
    .cts_ni(cts_n), .txd_o(txd), .fifo_empty_o(fifo_empty), .tx_idle_o(tx_idle),
    .pkt_done_o(pkt_done)
  );

  always @(negedge clk) if (pkt_done) pd_cnt++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nbits_exp();
    return 9 + int'(wake_en) + int'(par_en) + (two_stop ? 3 : 2);
  endfunction

  function automatic logic [13:0] mk_frame(input logic [7:0] b, input logic w);
    logic [13:0] f;
    int p;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[1+i] = b[i];
    p = 9;
    if (wake_en) begin f[p] = w; p++; end
    if (par_en) begin f[p] = par_even ? ^b : ~^b; p++; end
    return f;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  task automatic rx_frame(input logic [7:0] b, input logic w, input bit first, input string req);
    int nb, last;
    logic [13:0] got, exp;
    logic s_a, s_b;
    nb = nbits_exp();
    exp = mk_frame(b, w);
    last = (nb - 1) * bt + bt / 2;
    got = '1;
    s_a = 1'b1;
    s_b = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    for (int c = 0; c <= last; c++) begin
      if (c % bt == bt / 2) got[c / bt] = txd;
      if (c == bt - 1) s_a = txd;
      if (c == bt) s_b = txd;
      if (first && c == bt / 2) chk(tx_idle == 1'b0, "R10", "idle while sending", int'(tx_idle), 0);
      if (c < last) @(negedge clk);
    end
    chk(got == exp, req, "frame bits", int'(got), int'(exp));
    if (b[0]) chk(s_a == 1'b0 && s_b == 1'b1, "R2", "start bit length", int'({s_a, s_b}), 1);
  endtask

  // mode 0: open gate, 1: held by clear-to-send, 2: held by enable
  task automatic run_block(input int len, input int mode);
    logic [7:0] fb [70];
    logic       fw [70];
    logic [15:0] c;
    bit crc_on, quiet;
    int nfr, pd0;
    blk_len = 6'(len - 1);
    crc_on = crc_en && !par_en;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      fb[i] = 8'($urandom);
      if (i == 0) fb[i][0] = 1'b1;
      fw[i] = (i == 0);
      c = ref_crc(c, fb[i]);
    end
    nfr = len;
    if (crc_on) begin
      fb[len] = c[15:8]; fw[len] = 1'b0;
      fb[len+1] = c[7:0]; fw[len+1] = 1'b0;
      nfr = len + 2;
    end
    if (mode == 1) cts_n = 1'b1;
    if (mode == 2) tx_en = 1'b0;
    pd0 = pd_cnt;
    fork
      begin : writer
        int rem, idx, g;
        rem = len;
        idx = 0;
        while (rem > 0) begin
          g = (rem > 4) ? 4 : rem;
          @(negedge clk);
          while (!fifo_empty) @(negedge clk);
          for (int k = 0; k < g; k++) begin
            wr_valid = 1'b1;
            wr_data = fb[idx];
            idx++;
            @(negedge clk);
          end
          if (g >= 2) begin
            wr_data = 8'hEE;
            @(negedge clk);
          end
          wr_valid = 1'b0;
          rem -= g;
        end
      end
      begin : reader
        if (mode != 0) begin
          quiet = 1;
          repeat (3 * bt) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 0;
          end
          chk(quiet, "R4", "line held while gate closed", int'(quiet), 1);
          chk(fifo_empty == 1'b0, "R10", "bytes held not empty", int'(fifo_empty), 0);
          cts_n = 1'b0;
          tx_en = 1'b1;
        end
        for (int i = 0; i < nfr; i++) begin
          rx_frame(fb[i], fw[i], i == 0,
                   (i >= len) ? "R6" : (mode == 1 && i > 0) ? "R4" :
                   wake_en ? "R8" : par_en ? "R7" : "R3");
          if (mode == 1 && i == 0) cts_n = 1'b1;
        end
        quiet = 1;
        repeat (2 * bt) begin
          @(negedge clk);
          if (txd !== 1'b1) quiet = 0;
        end
        chk(quiet, "R5", "no extra frame after block", int'(quiet), 1);
        chk(pd_cnt == pd0 + 1, "R9", "block done pulses", pd_cnt - pd0, 1);
        chk(tx_idle == 1'b1 && fifo_empty == 1'b1, "R10", "idle after block",
            int'({tx_idle, fifo_empty}), 3);
      end
    join
    cts_n = 1'b0;
    tx_en = 1'b1;
  endtask

  task automatic set_rate(input logic sel, input logic [7:0] n);
    presc_sel = sel;
    div = n;
    bt = (sel ? 32 : 2) * (int'(n) + 1) * 16;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(txd == 1'b1 && fifo_empty == 1'b1 && tx_idle == 1'b1 && pkt_done == 1'b0, "R1",
        "reset outputs", int'({txd, fifo_empty, tx_idle, pkt_done}), 4'he);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && tx_idle == 1'b1, "R1", "after release", int'({txd, tx_idle}), 3);

    // 8-byte block with check bytes and wakeup: two full groups
    set_rate(1'b0, 8'd0);
    crc_en = 1; wake_en = 1; par_en = 0; two_stop = 0;
    run_block(8, 0);

    // slow prescaler, single byte, even parity, two stop bits
    set_rate(1'b1, 8'd0);
    crc_en = 0; wake_en = 0; par_en = 1; par_even = 1; two_stop = 1;
    run_block(1, 0);

    // parity and check bytes both on: parity wins, odd sense
    set_rate(1'b0, 8'd1);
    crc_en = 1; par_en = 1; par_even = 0; two_stop = 1; wake_en = 0;
    run_block(3, 0);

    // clear-to-send holds the block, then drops out mid-block
    set_rate(1'b0, 8'd0);
    crc_en = 1; par_en = 0; two_stop = 0; wake_en = 1;
    run_block(6, 1);

    // enable holds the block
    run_block(3, 2);

    // longest block
    crc_en = 1; par_en = 0; wake_en = 0; two_stop = 0;
    run_block(64, 0);

    for (int r = 0; r < 8; r++) begin
      set_rate(1'b0, 8'($urandom % 2));
      par_en   = 1'($urandom);
      par_even = 1'($urandom);
      crc_en   = 1'($urandom);
      two_stop = 1'($urandom);
      wake_en  = 1'($urandom);
      run_block(1 + int'($urandom % 6), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule